// File: doc/BRIEF.md
# Width-Switchable CPU Register Bank

This block is the architectural register store of a small 16-bit processor core. It holds a 16-bit accumulator, split into a visible low byte and a high byte that can be kept hidden. It also holds two index registers, a stack pointer, a direct-page base, an 8-bit status register and an emulation bit. Two status bits set the runtime width. `m` makes the accumulator 8 or 16 bits wide, and `x` does the same for both index registers. Every transfer copies only as much as the destination width allows, and it derives the negative and zero flags from the value it moved.

The block accepts at most one command per clock through a single command port. The commands are:
- clearing or setting status bits under a mask;
- exchanging carry with the emulation bit;
- swapping the two accumulator bytes;
- the twelve register-to-register moves;
- three write-back commands that load the accumulator or an index register from a data bus, at its current width. These are the path an external ALU or load unit uses to return results.

Fetch, memory access and arithmetic live elsewhere.

Top module: `cpu_regbank`

## Requirements
- R1: After reset the emulation bit is 1, the status register reads 0x34 (IRQ-disable, x and m set; carry, zero, decimal, overflow and negative clear), and the accumulator, both index registers, the stack pointer and the direct-page base are all zero.
- R2: Status bit positions are carry bit 0, zero bit 1, IRQ-disable bit 2, decimal bit 3, x bit 4, m bit 5, overflow bit 6, negative bit 7. The clear-mask command clears each status bit whose mask bit is 1 and leaves the bits whose mask bit is 0 unchanged.
- R3: The set-mask command sets each status bit whose mask bit is 1 and leaves the others unchanged.
- R4: m = 1 selects an 8-bit accumulator and m = 0 a 16-bit one; x encodes the index width the same way. While the emulation bit is 1, m and x always read 1, even right after a clear-mask command that names them.
- R5: Whenever x is 1, bits 15:8 of both index registers read zero. Entering x = 1 clears those bits on the same edge.
- R6: The exchange command swaps the carry bit and the emulation bit.
- R7: The byte-swap command exchanges the accumulator's low and high bytes. It sets negative from bit 7 of the new low byte and sets zero when the new low byte is 0x00, whatever the value of m.
- R8: With m = 1, any write or transfer into the accumulator (TXA, TYA, WRA) changes only the low byte and keeps the high byte.
- R9: Transfers into an index register (TAX, TAY, TSX, TXY, TYX, WRX, WRY) copy the low byte and zero-extend it when x = 1. When x = 0 they copy all 16 bits, even if m = 1.
- R10: Every transfer and write-back except TCS loads negative and zero from the moved value, taken at the destination width. TCS leaves the whole status register and the emulation bit unchanged. TXS writes the stack pointer and takes its flags at 16 bits.
- R11: TCD, TDC, TCS and TSC move all 16 bits between the accumulator and the direct-page base or the stack pointer, whatever the value of m.
- R12: The write-back commands WRA, WRX and WRY load `cmd_data` into the accumulator, X or Y at the destination's current width, and update negative and zero as in R10.
- R13: A command takes effect at the rising edge where `cmd_valid` is 1, and its result is visible right after that edge. With `cmd_valid` at 0 nothing changes. The `cmd_op` codes are: 0 none, 1 clear-mask, 2 set-mask, 3 exchange, 4 byte-swap, 5 TAX, 6 TAY, 7 TXA, 8 TYA, 9 TSX, 10 TXS, 11 TXY, 12 TYX, 13 TCD, 14 TDC, 15 TCS, 16 TSC, 17 WRA, 18 WRX, 19 WRY. The codes 20 to 31 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 5 | Command code (see R13) |
| cmd_mask | input | 8 | Status mask for the clear-mask and set-mask commands |
| cmd_data | input | 16 | Write-back value for WRA, WRX and WRY |
| acc_o | output | 16 | Accumulator, high byte over low byte |
| x_o | output | 16 | X index register |
| y_o | output | 16 | Y index register |
| sp_o | output | 16 | Stack pointer |
| dp_o | output | 16 | Direct-page base |
| status_o | output | 8 | Status register |
| emu_o | output | 1 | Emulation bit |
| flag_n_o | output | 1 | Current negative flag |
| flag_z_o | output | 1 | Current zero flag |

## Verification
Every result of this block, whether register contents, status bits or the emulation bit, is due exactly one rising edge after the command is presented. No result waits a further cycle. The bench applies each command at a falling edge and advances a behavioural model of the registers at the next rising edge. It compares every output against that model at the following falling edge, so no comparison ever falls on the edge where state changes. The directed checks use the same timing: each expected value is read half a cycle after the one edge that produces it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [4:0] {
    OP_NOP = 5'd0,
    OP_REP = 5'd1,
    OP_SEP = 5'd2,
    OP_XCE = 5'd3,
    OP_XBA = 5'd4,
    OP_TAX = 5'd5,
    OP_TAY = 5'd6,
    OP_TXA = 5'd7,
    OP_TYA = 5'd8,
    OP_TSX = 5'd9,
    OP_TXS = 5'd10,
    OP_TXY = 5'd11,
    OP_TYX = 5'd12,
    OP_TCD = 5'd13,
    OP_TDC = 5'd14,
    OP_TCS = 5'd15,
    OP_TSC = 5'd16,
    OP_WRA = 5'd17,
    OP_WRX = 5'd18,
    OP_WRY = 5'd19
  } rb_op_e;

  localparam int ST_C = 0;
  localparam int ST_Z = 1;
  localparam int ST_I = 2;
  localparam int ST_D = 3;
  localparam int ST_X = 4;
  localparam int ST_M = 5;
  localparam int ST_V = 6;
  localparam int ST_N = 7;

  localparam logic [7:0] ST_RESET = 8'h34;

  typedef struct packed {
    logic upd;
    logic n;
    logic z;
  } rb_nz_t;

endpackage

// File: rtl/rb_mover.sv
module rb_mover
  import regbank_pkg::*;
#(
  parameter int DW = 16
) (
  input  rb_op_e        op_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] xr_i,
  input  logic [DW-1:0] yr_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] dp_i,
  input  logic          mf_i,
  input  logic          xf_i,
  output logic          acc_we_o,
  output logic [DW-1:0] acc_nx_o,
  output logic [1:0]    idx_we_o,
  output logic [DW-1:0] x_nx_o,
  output logic [DW-1:0] y_nx_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_nx_o,
  output logic          dp_we_o,
  output logic [DW-1:0] dp_nx_o,
  output rb_nz_t        nz_o
);

  localparam int HW = DW / 2;

  function automatic rb_nz_t nz_of(input logic [DW-1:0] v, input logic narrow);
    rb_nz_t r;
    r.upd = 1'b1;
    if (narrow) begin
      r.n = v[HW-1];
      r.z = (v[HW-1:0] == '0);
    end else begin
      r.n = v[DW-1];
      r.z = (v == '0);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] idx_fit(input logic [DW-1:0] v, input logic narrow);
    return narrow ? {{HW{1'b0}}, v[HW-1:0]} : v;
  endfunction

  function automatic logic [DW-1:0] acc_fit(input logic [DW-1:0] v, input logic [DW-1:0] old,
                                            input logic narrow);
    return narrow ? {old[DW-1:HW], v[HW-1:0]} : v;
  endfunction

  always_comb begin
    acc_we_o = 1'b0;
    idx_we_o = 2'b00;
    sp_we_o  = 1'b0;
    dp_we_o  = 1'b0;
    acc_nx_o = acc_i;
    x_nx_o   = xr_i;
    y_nx_o   = yr_i;
    sp_nx_o  = sp_i;
    dp_nx_o  = dp_i;
    nz_o     = '0;
    case (op_i)
      OP_XBA: begin
        acc_we_o = 1'b1;
        acc_nx_o = {acc_i[HW-1:0], acc_i[DW-1:HW]};
        nz_o     = nz_of({{HW{1'b0}}, acc_i[DW-1:HW]}, 1'b1);
      end
      OP_WRA: begin
        acc_we_o = 1'b1;
        acc_nx_o = acc_fit(data_i, acc_i, mf_i);
        nz_o     = nz_of(data_i, mf_i);
      end
      OP_TXA: begin
        acc_we_o = 1'b1;
        acc_nx_o = acc_fit(xr_i, acc_i, mf_i);
        nz_o     = nz_of(xr_i, mf_i);
      end
      OP_TYA: begin
        acc_we_o = 1'b1;
        acc_nx_o = acc_fit(yr_i, acc_i, mf_i);
        nz_o     = nz_of(yr_i, mf_i);
      end
      OP_TDC: begin
        acc_we_o = 1'b1;
        acc_nx_o = dp_i;
        nz_o     = nz_of(dp_i, 1'b0);
      end
      OP_TSC: begin
        acc_we_o = 1'b1;
        acc_nx_o = sp_i;
        nz_o     = nz_of(sp_i, 1'b0);
      end
      OP_WRX: begin
        idx_we_o[0] = 1'b1;
        x_nx_o      = idx_fit(data_i, xf_i);
        nz_o        = nz_of(data_i, xf_i);
      end
      OP_TAX: begin
        idx_we_o[0] = 1'b1;
        x_nx_o      = idx_fit(acc_i, xf_i);
        nz_o        = nz_of(acc_i, xf_i);
      end
      OP_TSX: begin
        idx_we_o[0] = 1'b1;
        x_nx_o      = idx_fit(sp_i, xf_i);
        nz_o        = nz_of(sp_i, xf_i);
      end
      OP_TYX: begin
        idx_we_o[0] = 1'b1;
        x_nx_o      = idx_fit(yr_i, xf_i);
        nz_o        = nz_of(yr_i, xf_i);
      end
      OP_WRY: begin
        idx_we_o[1] = 1'b1;
        y_nx_o      = idx_fit(data_i, xf_i);
        nz_o        = nz_of(data_i, xf_i);
      end
      OP_TAY: begin
        idx_we_o[1] = 1'b1;
        y_nx_o      = idx_fit(acc_i, xf_i);
        nz_o        = nz_of(acc_i, xf_i);
      end
      OP_TXY: begin
        idx_we_o[1] = 1'b1;
        y_nx_o      = idx_fit(xr_i, xf_i);
        nz_o        = nz_of(xr_i, xf_i);
      end
      OP_TXS: begin
        sp_we_o = 1'b1;
        sp_nx_o = xr_i;
        nz_o    = nz_of(xr_i, 1'b0);
      end
      OP_TCS: begin
        sp_we_o = 1'b1;
        sp_nx_o = acc_i;
      end
      OP_TCD: begin
        dp_we_o = 1'b1;
        dp_nx_o = acc_i;
        nz_o    = nz_of(acc_i, 1'b0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rb_status.sv
module rb_status
  import regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rb_op_e     op_i,
  input  logic [7:0] mask_i,
  input  rb_nz_t     nz_i,
  output logic [7:0] p_o,
  output logic       e_o,
  output logic       x_next_o
);

  logic [7:0] p_q, p_d;
  logic       e_q, e_d;
  logic       st_en;

  always_comb begin
    p_d = p_q;
    e_d = e_q;
    case (op_i)
      OP_REP: p_d = p_q & ~mask_i;
      OP_SEP: p_d = p_q | mask_i;
      OP_XCE: begin
        e_d       = p_q[ST_C];
        p_d[ST_C] = e_q;
      end
      default: ;
    endcase
    if (nz_i.upd) begin
      p_d[ST_N] = nz_i.n;
      p_d[ST_Z] = nz_i.z;
    end
    if (e_d) begin
      p_d[ST_M] = 1'b1;
      p_d[ST_X] = 1'b1;
    end
  end

  assign st_en = (op_i != OP_NOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= ST_RESET;
      e_q <= 1'b1;
    end else if (st_en) begin
      p_q <= p_d;
      e_q <= e_d;
    end
  end

  assign p_o      = p_q;
  assign e_o      = e_q;
  assign x_next_o = p_d[ST_X];

  AST_REP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_REP && !e_q) |=> ((p_q & $past(mask_i)) == 8'h00)); // R2
  AST_SEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SEP) |=> ((p_q & $past(mask_i)) == $past(mask_i))); // R3
  AST_EMU_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> (p_q[ST_M] && p_q[ST_X])); // R4
  AST_XCE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_XCE) |=> (e_q == $past(p_q[ST_C]) && p_q[ST_C] == $past(e_q))); // R6

endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xf_i,
  input  logic          x_next_i,
  input  logic          acc_we_i,
  input  logic [DW-1:0] acc_nx_i,
  input  logic [1:0]    idx_we_i,
  input  logic [DW-1:0] x_nx_i,
  input  logic [DW-1:0] y_nx_i,
  input  logic          sp_we_i,
  input  logic [DW-1:0] sp_nx_i,
  input  logic          dp_we_i,
  input  logic [DW-1:0] dp_nx_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] dp_o
);

  localparam int HW   = DW / 2;
  localparam int NIDX = 2;

  logic [DW-1:0] acc_q, sp_q, dp_q;
  logic [DW-1:0] idx_q [NIDX];
  logic [DW-1:0] idx_d [NIDX];
  logic [DW-1:0] idx_nx [NIDX];
  logic [NIDX-1:0] idx_en;

  assign idx_nx[0] = x_nx_i;
  assign idx_nx[1] = y_nx_i;

  generate
    for (genvar gi = 0; gi < NIDX; gi++) begin : g_idx
      always_comb begin
        idx_d[gi] = idx_we_i[gi] ? idx_nx[gi] : idx_q[gi];
        if (x_next_i) idx_d[gi][DW-1:HW] = '0;
      end

      assign idx_en[gi] = idx_we_i[gi] | x_next_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q[gi] <= '0;
        else if (idx_en[gi]) idx_q[gi] <= idx_d[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_we_i) acc_q <= acc_nx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (sp_we_i) sp_q <= sp_nx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_q <= '0;
    else if (dp_we_i) dp_q <= dp_nx_i;
  end

  assign acc_o = acc_q;
  assign x_o   = idx_q[0];
  assign y_o   = idx_q[1];
  assign sp_o  = sp_q;
  assign dp_o  = dp_q;

  AST_IDX_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    xf_i |-> (idx_q[0][DW-1:HW] == '0 && idx_q[1][DW-1:HW] == '0)); // R5

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import regbank_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [4:0]    cmd_op,
  input  logic [7:0]    cmd_mask,
  input  logic [DW-1:0] cmd_data,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] x_o,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] dp_o,
  output logic [7:0]    status_o,
  output logic          emu_o,
  output logic          flag_n_o,
  output logic          flag_z_o
);

  localparam int HW = DW / 2;

  rb_op_e        op_eff;
  rb_nz_t        nz;
  logic [7:0]    p_q;
  logic          e_q, x_next;
  logic          acc_we, sp_we, dp_we;
  logic [1:0]    idx_we;
  logic [DW-1:0] acc_nx, x_nx, y_nx, sp_nx, dp_nx;

  assign op_eff = cmd_valid ? rb_op_e'(cmd_op) : OP_NOP;

  rb_mover #(.DW(DW)) u_mover (
    .op_i     (op_eff),
    .data_i   (cmd_data),
    .acc_i    (acc_o),
    .xr_i     (x_o),
    .yr_i     (y_o),
    .sp_i     (sp_o),
    .dp_i     (dp_o),
    .mf_i     (p_q[ST_M]),
    .xf_i     (p_q[ST_X]),
    .acc_we_o (acc_we),
    .acc_nx_o (acc_nx),
    .idx_we_o (idx_we),
    .x_nx_o   (x_nx),
    .y_nx_o   (y_nx),
    .sp_we_o  (sp_we),
    .sp_nx_o  (sp_nx),
    .dp_we_o  (dp_we),
    .dp_nx_o  (dp_nx),
    .nz_o     (nz)
  );

  rb_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_eff),
    .mask_i   (cmd_mask),
    .nz_i     (nz),
    .p_o      (p_q),
    .e_o      (e_q),
    .x_next_o (x_next)
  );

  rb_store #(.DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .xf_i     (p_q[ST_X]),
    .x_next_i (x_next),
    .acc_we_i (acc_we),
    .acc_nx_i (acc_nx),
    .idx_we_i (idx_we),
    .x_nx_i   (x_nx),
    .y_nx_i   (y_nx),
    .sp_we_i  (sp_we),
    .sp_nx_i  (sp_nx),
    .dp_we_i  (dp_we),
    .dp_nx_i  (dp_nx),
    .acc_o    (acc_o),
    .x_o      (x_o),
    .y_o      (y_o),
    .sp_o     (sp_o),
    .dp_o     (dp_o)
  );

  assign status_o = p_q;
  assign emu_o    = e_q;
  assign flag_n_o = p_q[ST_N];
  assign flag_z_o = p_q[ST_Z];

  AST_B_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status_o[ST_M] &&
     (cmd_op == 5'd7 || cmd_op == 5'd8 || cmd_op == 5'd17))
    |=> $stable(acc_o[DW-1:HW])); // R8
  AST_TCS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd15) |=> ($stable(status_o) && $stable(emu_o))); // R10
  AST_TCS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 5'd15) |=> (sp_o == $past(acc_o))); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(acc_o) && $stable(status_o) && $stable(emu_o) &&
                    $stable(sp_o) && $stable(dp_o))); // R13

endmodule

// File: tb/cpu_regbank_bench.sv
`timescale 1ns/1ps
module cpu_regbank_bench;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [4:0]  cmd_op;
  logic [7:0]  cmd_mask;
  logic [15:0] cmd_data;
  logic [15:0] acc_o, x_o, y_o, sp_o, dp_o;
  logic [7:0]  status_o;
  logic        emu_o, flag_n_o, flag_z_o;

  cpu_regbank u_cpu_regbank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_mask(cmd_mask), .cmd_data(cmd_data), .acc_o(acc_o), .x_o(x_o),
    .y_o(y_o), .sp_o(sp_o), .dp_o(dp_o), .status_o(status_o), .emu_o(emu_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int ma, mb, mx, my, ms, md, mp, me;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void set_nz(input int v, input int wide);
    int msk = wide ? 16'hFFFF : 8'hFF;
    int top = wide ? 16'h8000 : 8'h80;
    mp = mp & ~8'h82;
    if ((v & top) != 0) mp = mp | 8'h80;
    if ((v & msk) == 0) mp = mp | 8'h02;
  endfunction

  function automatic void put_acc(input int v);
    ma = v & 255;
    if ((mp & 8'h20) == 0) mb = (v >> 8) & 255;
    set_nz(v, ((mp & 8'h20) == 0) ? 1 : 0);
  endfunction

  function automatic int fit_idx(input int v);
    return ((mp & 8'h10) != 0) ? (v & 255) : (v & 16'hFFFF);
  endfunction

  function automatic void model_step(input int op, input int mask, input int data);
    int c = (mb << 8) | ma;
    int t;
    int iw = ((mp & 8'h10) == 0) ? 1 : 0;
    case (op)
      1: mp = mp & ~mask & 255;
      2: mp = mp | mask;
      3: begin t = me; me = mp & 1; mp = (mp & 8'hFE) | t; end
      4: begin t = ma; ma = mb; mb = t; set_nz(ma, 0); end
      5: begin mx = fit_idx(c);  set_nz(c, iw);  end
      6: begin my = fit_idx(c);  set_nz(c, iw);  end
      7: put_acc(mx);
      8: put_acc(my);
      9: begin mx = fit_idx(ms); set_nz(ms, iw); end
      10: begin ms = mx; set_nz(mx, 1); end
      11: begin my = fit_idx(mx); set_nz(mx, iw); end
      12: begin mx = fit_idx(my); set_nz(my, iw); end
      13: begin md = c; set_nz(c, 1); end
      14: begin ma = md & 255; mb = md >> 8; set_nz(md, 1); end
      15: ms = c;
      16: begin ma = ms & 255; mb = ms >> 8; set_nz(ms, 1); end
      17: put_acc(data);
      18: begin mx = fit_idx(data); set_nz(data, iw); end
      19: begin my = fit_idx(data); set_nz(data, iw); end
      default: ;
    endcase
    if (me != 0) mp = mp | 8'h30;
    if ((mp & 8'h10) != 0) begin mx = mx & 255; my = my & 255; end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ma = 0; mb = 0; mx = 0; my = 0; ms = 0; md = 0; mp = 8'h34; me = 1;
    end else if (cmd_valid) begin
      model_step(int'(cmd_op), int'(cmd_mask), int'(cmd_data));
    end
  end

  // compare against the model half a cycle after every edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, int'(acc_o), (mb << 8) | ma, "acc");
      chk(cur_req, int'(x_o), mx, "x");
      chk(cur_req, int'(y_o), my, "y");
      chk(cur_req, int'(sp_o), ms, "sp");
      chk(cur_req, int'(dp_o), md, "dp");
      chk(cur_req, int'(status_o), mp, "status");
      chk(cur_req, int'(emu_o), me, "emu");
      chk(cur_req, int'({flag_n_o, flag_z_o}), ((mp >> 6) & 2) | ((mp >> 1) & 1), "nz");
    end
  end

  task automatic step(input int op, input int mask, input int data, input string req);
    cur_req   = req;
    cmd_valid = 1'b1;
    cmd_op    = op[4:0];
    cmd_mask  = mask[7:0];
    cmd_data  = data[15:0];
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rs = 32'h1ACE_B00C;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_mask = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(status_o), 8'h34, "reset status");
    chk("R1", int'(emu_o), 1, "reset emu");
    chk("R1", int'(acc_o), 0, "reset acc");

    step(17, 0, 16'h1234, "R12"); chk("R12", int'(acc_o), 16'h0034, "WRA narrow");
    step(3, 0, 0, "R6");          chk("R6", int'({emu_o, status_o}), 9'h035, "XCE native");
    step(1, 8'h30, 0, "R2");      chk("R2", int'(status_o), 8'h05, "REP m x");
    step(17, 0, 16'h8001, "R12"); chk("R12", int'(acc_o), 16'h8001, "WRA wide");
                                  chk("R12", int'(status_o), 8'h85, "WRA flags");
    step(5, 0, 0, "R9");          chk("R9", int'(x_o), 16'h8001, "TAX wide");
    step(2, 8'h20, 0, "R3");      chk("R3", int'(status_o), 8'hA5, "SEP m");
    step(6, 0, 0, "R9");          chk("R9", int'(y_o), 16'h8001, "TAY x0 m1");
    step(17, 0, 16'h0000, "R8");  chk("R8", int'(acc_o), 16'h8000, "WRA keeps B");
                                  chk("R10", int'(status_o), 8'h27, "zero flag");
    step(4, 0, 0, "R7");          chk("R7", int'(acc_o), 16'h0080, "XBA swap");
                                  chk("R7", int'(status_o), 8'hA5, "XBA flags");
    step(4, 0, 0, "R7");          chk("R7", int'(status_o), 8'h27, "XBA zero");
    step(7, 0, 0, "R8");          chk("R8", int'(acc_o), 16'h8001, "TXA keeps B");
                                  chk("R10", int'(status_o), 8'h25, "TXA narrow nz");
    step(15, 0, 0, "R10");        chk("R11", int'(sp_o), 16'h8001, "TCS full");
                                  chk("R10", int'(status_o), 8'h25, "TCS no flags");
    step(13, 0, 0, "R11");        chk("R11", int'(dp_o), 16'h8001, "TCD full");
    step(2, 8'h10, 0, "R5");      chk("R5", int'(x_o), 16'h0001, "x high cleared");
                                  chk("R5", int'(y_o), 16'h0001, "y high cleared");
    cur_req = "R13"; cmd_op = 5'd4; cmd_valid = 1'b0; @(negedge clk);
    chk("R13", int'(acc_o), 16'h8001, "idle hold");
    step(10, 0, 0, "R10");        chk("R10", int'(sp_o), 16'h0001, "TXS");
    step(17, 0, 16'h0055, "R12"); chk("R12", int'(acc_o), 16'h8055, "WRA narrow");
    step(16, 0, 0, "R11");        chk("R11", int'(acc_o), 16'h0001, "TSC full");
    step(3, 0, 0, "R6");          chk("R6", int'(emu_o), 1, "XCE emu");
                                  chk("R6", int'(status_o), 8'h34, "XCE carry");
    step(1, 8'h30, 0, "R4");      chk("R4", int'(status_o), 8'h34, "emu forces m x");

    for (int i = 0; i < 600; i++) begin
      int op, mk, dt;
      rs = rs ^ (rs << 13); rs = rs ^ (rs >>> 17); rs = rs ^ (rs << 5);
      op = (rs & 32'h7FFF_FFFF) % 21;
      mk = (rs >> 8) & 255;
      dt = (rs >> 12) & 16'hFFFF;
      if (op == 20) op = 22;
      step(op, mk, dt, "R13");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule